// File: doc/BRIEF.md
# Byte/Word Data Memory Access Unit

This block is the data-memory port of a small 16-bit core. It accepts one request per clock. A request is a load or a store of either one byte or one 16-bit word, and it is addressed by a byte-granular 16-bit effective address (EA). The EA comes either straight from the request or from an internal pointer register. The pointer can be loaded, used as-is, or used and then advanced by the size of the access (post-increment). The storage behind the port is two byte-wide halves that share one word-address decode and have independent write enables.

Byte loads fetch the containing word and use EA bit 0 to pick the lane. The lanes are little-endian: an even address selects the low half. The chosen byte is returned on the low byte of the read bus, with the high byte cleared. Byte stores touch only the matching half. Word accesses must be even. A word access at an odd EA is not split. Instead it raises a one-cycle address-error trap, and it neither writes memory nor moves the pointer.

Top module: `bwmu_top`

## Requirements
- R1: `reqMode` selects the EA source. 0 = direct (EA = `reqAddr`, pointer untouched). 1 = indirect (EA = pointer, pointer untouched). 2 = post-increment (EA = pointer, then the pointer advances). 3 = pointer load (pointer <= `reqAddr`, no memory access, no trap, no read response).
- R2: A post-increment access adds 1 to the pointer for a byte access and 2 for a word access, modulo 2^16. The new value appears on `ptrValue` after the request's clock edge.
- R3: A byte read returns, on `rdData[7:0]`, the low half of the addressed word when EA[0]=0 and the high half when EA[0]=1. `rdData[15:8]` is zero.
- R4: A word write at an even EA stores `reqWdata[7:0]` in the low half and `reqWdata[15:8]` in the high half. A word read at an even EA returns {high half, low half}.
- R5: A byte write stores `reqWdata[7:0]` in the half chosen by EA[0] and leaves the other half of that word unchanged. `reqWdata[15:8]` is ignored.
- R6: A word read or write with EA[0]=1 asserts `addrTrap` for exactly the one cycle after the request edge. It writes neither half, does not move the pointer and produces no `rdValid`.
- R7: A read request yields `rdValid`=1 and its data in the cycle after the request edge. `rdData` is zero whenever `rdValid` is 0. A write is visible to a read issued in the very next cycle.
- R8: The word index is EA[MEM_WORD_AW:1] (bits [8:1] by default). Higher EA bits are ignored, so addresses 2^(MEM_WORD_AW+1) bytes apart alias.
- R9: While reset (`rstN` low) is asserted, `ptrValue`, `rdData`, `rdValid` and `addrTrap` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqMode | input | 2 | EA source / pointer mode (R1) |
| reqAddr | input | 16 | Direct EA, or the value for a pointer load |
| reqWdata | input | 16 | Store data |
| rdData | output | 16 | Load data, valid with rdValid |
| rdValid | output | 1 | Load response strobe |
| addrTrap | output | 1 | Misaligned word access pulse |
| ptrValue | output | 16 | Current pointer register |

## Verification
The bound checker watches four things on every cycle:
- a trap occurs exactly when the previous cycle carried an odd-EA word request;
- a trap never coincides with a held or stepped pointer change;
- no write enable rises for a faulting word request, and both write enables rise together only for a word access;
- post-increment steps by the access size, and a byte load clears the upper read byte.

Several behaviours need the bench's stored-contents model to show, because they are properties of memory contents rather than of single cycles:
- lane selection;
- the survival of the untouched half after a byte store;
- address aliasing;
- read-after-write visibility;
- the absence of any write by a trapped store.

// File: rtl/bwmu_pkg.sv
package bwmu_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'd0,
    MODE_IND     = 2'd1,
    MODE_POSTINC = 2'd2,
    MODE_PTRLD   = 2'd3
  } ptrMode_e;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic rdEn;
    logic wrLo;
    logic wrHi;
    logic laneHi;
    logic wordOp;
    logic ptrLoad;
    logic ptrStep;
    logic trap;
  } ctrlStrobe_t;

endpackage

// File: rtl/bwmu_lane.sv
// One byte-wide half of the data array: own write enable, registered read.
module bwmu_lane #(
  parameter int AW = 8,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rdEn,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdQ
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wdata;
    if (rdEn) rdQ <= mem[addr];
  end
endmodule

// File: rtl/bwmu_ctrl.sv
// Request decode: alignment check and strobe generation.
module bwmu_ctrl
  import bwmu_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqWord,
  input  logic [1:0]  reqMode,
  input  logic        eaLsb,
  output ctrlStrobe_t strobe
);
  ptrMode_e mode;
  logic     memAccess;
  logic     misaligned;
  logic     okAccess;

  always_comb begin
    mode       = ptrMode_e'(reqMode);
    memAccess  = reqValid && (mode != MODE_PTRLD);
    misaligned = memAccess && reqWord && eaLsb;
    okAccess   = memAccess && !misaligned;

    strobe         = '0;
    strobe.trap    = misaligned;
    strobe.rdEn    = okAccess && !reqWrite;
    strobe.wrLo    = okAccess && reqWrite && (reqWord || !eaLsb);
    strobe.wrHi    = okAccess && reqWrite && (reqWord || eaLsb);
    strobe.laneHi  = eaLsb;
    strobe.wordOp  = reqWord;
    strobe.ptrLoad = reqValid && (mode == MODE_PTRLD);
    strobe.ptrStep = okAccess && (mode == MODE_POSTINC);
  end
endmodule

// File: rtl/bwmu_dpath.sv
// Address generation, pointer register, dual-lane array and read alignment.
module bwmu_dpath
  import bwmu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LANE_W      = 8,
  parameter int MEM_WORD_AW = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            reqMode,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2*LANE_W-1:0]   reqWdata,
  input  ctrlStrobe_t           strobe,
  output logic                  eaLsb,
  output logic [ADDR_W-1:0]     ptrValue,
  output logic [2*LANE_W-1:0]   rdData,
  output logic                  rdValid,
  output logic                  addrTrap
);
  localparam int DATA_W = 2 * LANE_W;
  localparam int LANES  = 2;
  localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);

  logic [ADDR_W-1:0]      ptrQ;
  logic [ADDR_W-1:0]      ea;
  logic [MEM_WORD_AW-1:0] wordAddr;
  logic                   unusedEaHigh;
  logic [LANE_W-1:0]      laneRd [LANES];
  logic                   rdValidQ;
  logic                   laneHiQ;
  logic                   wordQ;
  logic                   trapQ;

  // Effective address: direct field or pointer register.
  always_comb begin
    ea = (ptrMode_e'(reqMode) == MODE_DIRECT) ? reqAddr : ptrQ;
  end
  assign eaLsb        = ea[0];
  assign wordAddr     = ea[MEM_WORD_AW:1];
  assign unusedEaHigh = ^ea[ADDR_W-1:MEM_WORD_AW+1];

  // Pointer register with size-scaled post-increment.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strobe.ptrLoad) begin
      ptrQ <= reqAddr;
    end else if (strobe.ptrStep) begin
      ptrQ <= ptrQ + (strobe.wordOp ? STEP_WORD : STEP_BYTE);
    end
  end

  // Two byte-wide halves with a shared word decode.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic              laneWr;
    logic [LANE_W-1:0] laneWd;
    if (g == 0) begin : gLo
      assign laneWr = strobe.wrLo;
      assign laneWd = reqWdata[LANE_W-1:0];
    end else begin : gHi
      assign laneWr = strobe.wrHi;
      assign laneWd = strobe.wordOp ? reqWdata[DATA_W-1:LANE_W]
                                    : reqWdata[LANE_W-1:0];
    end
    bwmu_lane #(
      .AW (MEM_WORD_AW),
      .W  (LANE_W)
    ) u_lane (
      .clk   (clk),
      .rdEn  (strobe.rdEn),
      .wrEn  (laneWr),
      .addr  (wordAddr),
      .wdata (laneWd),
      .rdQ   (laneRd[g])
    );
  end

  // Response registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      laneHiQ  <= 1'b0;
      wordQ    <= 1'b0;
      trapQ    <= 1'b0;
    end else begin
      rdValidQ <= strobe.rdEn;
      trapQ    <= strobe.trap;
      if (strobe.rdEn) begin
        laneHiQ <= strobe.laneHi;
        wordQ   <= strobe.wordOp;
      end
    end
  end

  // Lane steering onto the read bus.
  always_comb begin
    rdData = '0;
    if (rdValidQ) begin
      if (wordQ) begin
        rdData = {laneRd[1], laneRd[0]};
      end else begin
        rdData[LANE_W-1:0] = laneHiQ ? laneRd[1] : laneRd[0];
      end
    end
  end

  assign ptrValue = ptrQ;
  assign rdValid  = rdValidQ;
  assign addrTrap = trapQ;
endmodule

// File: rtl/bwmu_top.sv
module bwmu_top
  import bwmu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LANE_W      = 8,
  parameter int MEM_WORD_AW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqWord,
  input  logic [1:0]          reqMode,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*LANE_W-1:0] reqWdata,
  output logic [2*LANE_W-1:0] rdData,
  output logic                rdValid,
  output logic                addrTrap,
  output logic [ADDR_W-1:0]   ptrValue
);
  ctrlStrobe_t strobe;
  logic        eaLsb;

  bwmu_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqWord  (reqWord),
    .reqMode  (reqMode),
    .eaLsb    (eaLsb),
    .strobe   (strobe)
  );

  bwmu_dpath #(
    .ADDR_W      (ADDR_W),
    .LANE_W      (LANE_W),
    .MEM_WORD_AW (MEM_WORD_AW)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .reqMode  (reqMode),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .strobe   (strobe),
    .eaLsb    (eaLsb),
    .ptrValue (ptrValue),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .addrTrap (addrTrap)
  );
endmodule

// File: rtl/bwmu_checker.sv
module bwmu_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqWord,
  input logic [1:0]        reqMode,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              addrTrap,
  input logic [ADDR_W-1:0] ptrValue,
  input logic              wrLo,
  input logic              wrHi
);
  logic eaBit;
  logic memReq;
  logic oddWord;

  assign eaBit   = (reqMode == 2'd0) ? reqAddr[0] : ptrValue[0];
  assign memReq  = reqValid && (reqMode != 2'd3);
  assign oddWord = memReq && reqWord && eaBit;

  a_r6_trap_follows_odd_word: assert property (@(posedge clk) disable iff (!rstN)
    oddWord |=> addrTrap);

  a_r6_trap_needs_cause: assert property (@(posedge clk) disable iff (!rstN)
    addrTrap |-> $past(reqValid && reqWord));

  a_r6_no_write_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    oddWord |-> !(wrLo || wrHi));

  a_r6_ptr_held_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    (oddWord && reqMode == 2'd2) |=> $stable(ptrValue));

  a_r6_no_read_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    addrTrap |-> !rdValid);

  a_r5_single_lane_byte: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo && wrHi) |-> reqWord);

  a_r2_postinc_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && reqMode == 2'd2 && !oddWord) |=>
      ptrValue == $past(ptrValue) + ($past(reqWord) ? 16'd2 : 16'd1));

  a_r3_upper_byte_zero: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !reqWrite && !reqWord) |=> (rdValid && rdData[15:8] == 8'h00));

  a_r7_data_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> rdData == '0);
endmodule

bind bwmu_top bwmu_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (2*LANE_W)
) u_bwmu_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqWord  (reqWord),
  .reqMode  (reqMode),
  .reqAddr  (reqAddr),
  .rdData   (rdData),
  .rdValid  (rdValid),
  .addrTrap (addrTrap),
  .ptrValue (ptrValue),
  .wrLo     (strobe.wrLo),
  .wrHi     (strobe.wrHi)
);

// File: tb/bwmu_top_bench.sv
module bwmu_top_bench;
  localparam int MEM_WORD_AW = 8;
  localparam int NWORDS      = 1 << MEM_WORD_AW;
  localparam int NBYTES      = 2 * NWORDS;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqWord;
  logic [1:0]  reqMode;
  logic [15:0] reqAddr, reqWdata;
  logic [15:0] rdData, ptrValue;
  logic        rdValid, addrTrap;

  int vectors     = 0;
  int miscompares = 0;
  logic [15:0] model [NWORDS];
  logic [15:0] ptrModel;

  always #5 clk = ~clk;

  bwmu_top #(.MEM_WORD_AW(MEM_WORD_AW)) u_bwmu_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqMode(reqMode), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rdData(rdData), .rdValid(rdValid),
    .addrTrap(addrTrap), .ptrValue(ptrValue)
  );

  function automatic int widx(logic [15:0] a);
    return int'(a[MEM_WORD_AW:1]);
  endfunction

  function automatic logic [15:0] pat(int w);
    return 16'(w * 16'h9E37 + 16'h1357);
  endfunction

  function automatic logic [15:0] byteExp(logic [15:0] a);
    return a[0] ? {8'h00, model[widx(a)][15:8]} : {8'h00, model[widx(a)][7:0]};
  endfunction

  task automatic cmp(string req, string what, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, wait one full cycle; outputs then belong to this request.
  task automatic issue(logic wr, logic wd, logic [1:0] m, logic [15:0] a, logic [15:0] d);
    reqValid = 1'b1; reqWrite = wr; reqWord = wd; reqMode = m;
    reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expRead(string req, logic [15:0] exp);
    cmp(req, "rdValid", {15'b0, rdValid}, 16'd1);
    cmp(req, "rdData", rdData, exp);
    cmp(req, "addrTrap", {15'b0, addrTrap}, 16'd0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqWord = 1'b0;
    reqMode = 2'd0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    cmp("R9", "ptrValue", ptrValue, 16'h0);
    cmp("R9", "rdData", rdData, 16'h0);
    cmp("R9", "rdValid", {15'b0, rdValid}, 16'd0);
    cmp("R9", "addrTrap", {15'b0, addrTrap}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: fill every word with direct word writes
    for (int w = 0; w < NWORDS; w++) begin
      issue(1'b1, 1'b1, 2'd0, 16'(2 * w), pat(w));
      model[w] = pat(w);
      cmp("R7", "rdValid on write", {15'b0, rdValid}, 16'd0);
      cmp("R7", "rdData on write", rdData, 16'h0);
    end

    // R4: word reads at every even address
    for (int w = 0; w < NWORDS; w++) begin
      issue(1'b0, 1'b1, 2'd0, 16'(2 * w), 16'h0);
      expRead("R4", model[w]);
    end

    // R3: byte reads at every byte address, both lanes
    for (int b = 0; b < NBYTES; b++) begin
      issue(1'b0, 1'b0, 2'd0, 16'(b), 16'h0);
      expRead("R3", byteExp(16'(b)));
    end

    // R6: odd word writes and reads trap, memory untouched, pulse is one cycle
    for (int a = 1; a < NBYTES; a += 34) begin
      issue(1'b1, 1'b1, 2'd0, 16'(a), 16'hDEAD);
      cmp("R6", "addrTrap on odd write", {15'b0, addrTrap}, 16'd1);
      cmp("R6", "rdValid on odd write", {15'b0, rdValid}, 16'd0);
      issue(1'b0, 1'b1, 2'd0, 16'(a - 1), 16'h0);
      expRead("R6", model[widx(16'(a - 1))]);
      issue(1'b0, 1'b1, 2'd0, 16'(a + 1), 16'h0);
      expRead("R6", model[widx(16'(a + 1))]);
      issue(1'b0, 1'b1, 2'd0, 16'(a), 16'h0);
      cmp("R6", "addrTrap on odd read", {15'b0, addrTrap}, 16'd1);
      cmp("R6", "rdValid on odd read", {15'b0, rdValid}, 16'd0);
      cmp("R6", "rdData on odd read", rdData, 16'h0);
    end

    // R5: byte writes touch only the selected half; upper write byte ignored
    for (int b = 0; b < NBYTES; b += 3) begin
      logic [7:0] bv;
      bv = 8'(b * 7 + 1);
      issue(1'b1, 1'b0, 2'd0, 16'(b), {8'hEE, bv});
      if (b % 2 == 1) model[widx(16'(b))][15:8] = bv;
      else            model[widx(16'(b))][7:0]  = bv;
      issue(1'b0, 1'b1, 2'd0, 16'(b & ~1), 16'h0);
      expRead("R5", model[widx(16'(b))]);
    end

    // R7: back-to-back write then read of the same word
    issue(1'b1, 1'b1, 2'd0, 16'h0040, 16'hBEEF);
    model[widx(16'h0040)] = 16'hBEEF;
    issue(1'b0, 1'b1, 2'd0, 16'h0040, 16'h0);
    expRead("R7", 16'hBEEF);

    // R1: pointer load has no access
    issue(1'b0, 1'b1, 2'd3, 16'h0010, 16'h0);
    ptrModel = 16'h0010;
    cmp("R1", "ptrValue after load", ptrValue, ptrModel);
    cmp("R1", "rdValid after load", {15'b0, rdValid}, 16'd0);
    cmp("R1", "addrTrap after load", {15'b0, addrTrap}, 16'd0);

    // R2: post-increment byte reads
    for (int i = 0; i < 20; i++) begin
      logic [15:0] e;
      e = ptrModel;
      issue(1'b0, 1'b0, 2'd2, 16'h0, 16'h0);
      expRead("R2", byteExp(e));
      ptrModel = ptrModel + 16'd1;
      cmp("R2", "ptr byte step", ptrValue, ptrModel);
    end
    // R2: post-increment word reads (pointer now even)
    for (int i = 0; i < 20; i++) begin
      logic [15:0] e;
      e = ptrModel;
      issue(1'b0, 1'b1, 2'd2, 16'h0, 16'h0);
      expRead("R2", model[widx(e)]);
      ptrModel = ptrModel + 16'd2;
      cmp("R2", "ptr word step", ptrValue, ptrModel);
    end

    // R1: indirect mode leaves the pointer alone
    issue(1'b0, 1'b1, 2'd1, 16'h0, 16'h0);
    expRead("R1", model[widx(ptrModel)]);
    cmp("R1", "ptr after indirect", ptrValue, ptrModel);

    // R6: odd pointer, post-increment word traps and holds the pointer
    issue(1'b0, 1'b0, 2'd3, 16'h0021, 16'h0);
    ptrModel = 16'h0021;
    issue(1'b1, 1'b1, 2'd2, 16'h0, 16'h1111);
    cmp("R6", "addrTrap postinc", {15'b0, addrTrap}, 16'd1);
    cmp("R6", "ptr held on trap", ptrValue, ptrModel);
    issue(1'b0, 1'b1, 2'd0, 16'h0020, 16'h0);
    expRead("R6", model[widx(16'h0020)]);

    // R2/R5: post-increment byte write at odd pointer
    issue(1'b1, 1'b0, 2'd2, 16'h0, 16'h77A9);
    model[widx(ptrModel)][15:8] = 8'hA9;
    ptrModel = ptrModel + 16'd1;
    cmp("R2", "ptr after byte write", ptrValue, ptrModel);
    issue(1'b0, 1'b1, 2'd0, 16'h0020, 16'h0);
    expRead("R5", model[widx(16'h0020)]);

    // R2: wrap-around modulo 2^16
    issue(1'b0, 1'b0, 2'd3, 16'hFFFF, 16'h0);
    issue(1'b0, 1'b0, 2'd2, 16'h0, 16'h0);
    expRead("R2", byteExp(16'hFFFF));
    cmp("R2", "byte wrap", ptrValue, 16'h0000);
    issue(1'b0, 1'b0, 2'd3, 16'hFFFE, 16'h0);
    issue(1'b0, 1'b1, 2'd2, 16'h0, 16'h0);
    expRead("R2", model[widx(16'hFFFE)]);
    cmp("R2", "word wrap", ptrValue, 16'h0000);

    // R8: high EA bits alias onto the same word
    for (int k = 1; k < 8; k++) begin
      logic [15:0] a;
      a = 16'(k * 16'h0200 + k * 6);
      issue(1'b0, 1'b1, 2'd0, a, 16'h0);
      expRead("R8", model[widx(16'(k * 6))]);
    end

    finishRun();
  end
endmodule